// File: doc/BRIEF.md
# Double-Buffered USB OUT Endpoint Buffer

This block is the receive buffer behind one USB device OUT endpoint. It holds 256 bytes as two 128-byte packet slots used in ping-pong order: incoming packets fill the slots alternately, and the processor drains them in the order they arrived. The USB side delivers an already decoded byte stream framed by a start strobe and an end strobe, with a CRC verdict given at the end. When an OUT token arrives, the block tells the protocol engine whether to acknowledge it or refuse it. A packet is refused while the slot it would fill still holds an unread packet.

On the processor side, a read-only 32-bit data word shows the head byte of the oldest complete packet in bits 7:0. Each read strobe consumes that byte. A slot is released only when its last byte has been read, so refusals go on until a whole slot is free again. Each slot reports the length it captured at end of packet. A sticky interrupt marks every packet that is accepted, and a write-one-to-clear strobe clears it.

Top module: `usb_out_pingpong`

## Requirements
- R1: While reset is asserted and after it is released, `irq`, `hs_ack` and `hs_nak` are 0, both slot lengths are 0 and `cpu_rdata` is 0x00000000.
- R2: A packet of 1 to 128 bytes that ends with `rx_crc_ok`=1 is accepted into the next slot in turn (slot 0 first, then alternating). From the cycle after the end strobe, that slot's length output shows the byte count.
- R3: An accepted packet sets `irq`, which stays set until `irq_clr`. A clear leaves `irq` set when both slots hold unread packets at that moment, and otherwise drops it to 0.
- R4: A packet ending with `rx_crc_ok`=0 is dropped. `irq` is not raised, the slot lengths do not change, and the next token is acknowledged.
- R5: A packet of more than 128 bytes, or of zero bytes, is dropped in the same way as a CRC failure.
- R6: `cpu_rdata` shows the head byte of the oldest complete packet in bits 7:0, with bits 31:8 always 0. Each cycle with `cpu_rd`=1 consumes one byte, and the bytes come out in the order they were received.
- R7: While no complete packet is waiting, `cpu_rdata` is 0 and `cpu_rd` has no effect. A later packet is still read from its first byte.
- R8: An `tok_out` pulse gives a one-cycle `hs_ack` in the next cycle if the slot due to be filled is free, and a one-cycle `hs_nak` if it is not. With both slots full, NAK persists while the older packet is partly read. ACK returns only after its last byte has been read.
- R9: Packets are read out in the order they were accepted, across both slots.
- R10: A start strobe that targets a full slot is ignored. The bytes that follow it are not stored, and no length or slot state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| rx_sop | input | 1 | Start of packet strobe |
| rx_valid | input | 1 | Data byte strobe |
| rx_data | input | 8 | Received data byte |
| rx_eop | input | 1 | End of packet strobe (carries no data) |
| rx_crc_ok | input | 1 | CRC verdict, sampled with `rx_eop` |
| tok_out | input | 1 | An OUT token to this endpoint has arrived |
| hs_ack | output | 1 | Answer ACK (one-cycle pulse) |
| hs_nak | output | 1 | Answer NAK (one-cycle pulse) |
| cpu_rd | input | 1 | Read strobe for the data word; consumes one byte |
| cpu_rdata | output | 32 | Data word: head byte in 7:0, zeros above |
| slot0_len | output | 8 | Byte count captured for slot 0 |
| slot1_len | output | 8 | Byte count captured for slot 1 |
| irq | output | 1 | Sticky packet-received interrupt |
| irq_clr | input | 1 | Write-one-to-clear strobe for `irq` |

## Verification
A wrong full flag shows up on the next token: it answers with the opposite handshake one cycle later, or it leaves a drained packet readable again on `cpu_rdata`. A wrong fill pointer or slot selector shows up as a wrong length on the slot length output the cycle after the end strobe. It also shows up as wrong bytes when that packet is read. A wrong read pointer or release condition shows up immediately as a byte out of sequence. It can also show up as an ACK given before the last byte is gone. The tests read out every accepted packet in full, so each of these faults becomes visible within one packet.

// File: rtl/usbo_pkg.sv
package usbo_pkg;
  typedef enum logic [1:0] {
    HS_IDLE = 2'd0,
    HS_ACK  = 2'd1,
    HS_NAK  = 2'd2
  } hs_e;
endpackage

// File: rtl/usbo_slot_ram.sv
module usbo_slot_ram #(
  parameter int NSLOT      = 2,
  parameter int SLOT_BYTES = 128,
  localparam int SW        = $clog2(NSLOT),
  localparam int AW        = $clog2(SLOT_BYTES)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [SW-1:0] wr_slot,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic [SW-1:0] rd_slot,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_q
);
  logic [7:0] mem [NSLOT][SLOT_BYTES];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_slot][wr_addr] <= wr_data;
  end

  assign rd_q = mem[rd_slot][rd_addr];
endmodule

// File: rtl/usbo_rx_fill.sv
module usbo_rx_fill
  import usbo_pkg::*;
#(
  parameter int SLOT_BYTES = 128,
  localparam int AW        = $clog2(SLOT_BYTES),
  localparam int CW        = $clog2(SLOT_BYTES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sop,
  input  logic          valid,
  input  logic          eop,
  input  logic          crc_ok,
  input  logic          tok,
  input  logic [1:0]    slot_full,
  output logic          wr_en,
  output logic          wr_slot,
  output logic [AW-1:0] wr_addr,
  output logic          commit,
  output logic          commit_slot,
  output logic [CW-1:0] commit_len,
  output hs_e           hs
);
  logic          active_q, active_d;
  logic          ovf_q, ovf_d;
  logic          wsel_q, wsel_d;
  logic [CW-1:0] ptr_q, ptr_d;
  hs_e           hs_q, hs_d;

  always_comb begin
    active_d = active_q;
    ovf_d    = ovf_q;
    wsel_d   = wsel_q;
    ptr_d    = ptr_q;
    wr_en    = 1'b0;
    commit   = 1'b0;
    if (sop) begin
      active_d = !slot_full[wsel_q];
      ptr_d    = '0;
      ovf_d    = 1'b0;
    end else if (eop) begin
      if (active_q) begin
        active_d = 1'b0;
        if (crc_ok && !ovf_q && (ptr_q != '0)) begin
          commit = 1'b1;
          wsel_d = ~wsel_q;
        end
      end
    end else if (valid && active_q) begin
      if (ptr_q == CW'(SLOT_BYTES)) begin
        ovf_d = 1'b1;
      end else begin
        wr_en = 1'b1;
        ptr_d = ptr_q + 1'b1;
      end
    end
    if (tok) hs_d = slot_full[wsel_q] ? HS_NAK : HS_ACK;
    else     hs_d = HS_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      ovf_q    <= 1'b0;
      wsel_q   <= 1'b0;
      ptr_q    <= '0;
      hs_q     <= HS_IDLE;
    end else begin
      active_q <= active_d;
      ovf_q    <= ovf_d;
      wsel_q   <= wsel_d;
      ptr_q    <= ptr_d;
      hs_q     <= hs_d;
    end
  end

  assign wr_slot     = wsel_q;
  assign wr_addr     = ptr_q[AW-1:0];
  assign commit_slot = wsel_q;
  assign commit_len  = ptr_q;
  assign hs          = hs_q;

  AST_WRITE_INTO_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !slot_full[wr_slot]); // R10
  AST_PTR_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_q <= CW'(SLOT_BYTES)); // R5
endmodule

// File: rtl/usbo_rd_drain.sv
module usbo_rd_drain #(
  parameter int SLOT_BYTES = 128,
  localparam int AW        = $clog2(SLOT_BYTES),
  localparam int CW        = $clog2(SLOT_BYTES + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rd,
  input  logic [1:0]         slot_full,
  input  logic [1:0][CW-1:0] cnt,
  output logic               ready,
  output logic               rd_slot,
  output logic [AW-1:0]      rd_addr,
  output logic               release_pulse
);
  logic          rsel_q, rsel_d;
  logic [AW-1:0] rptr_q, rptr_d;
  logic          pop, last;

  always_comb begin
    ready         = slot_full[rsel_q];
    last          = (CW'(rptr_q) + CW'(1)) == cnt[rsel_q];
    pop           = rd && ready;
    release_pulse = pop && last;
    rsel_d        = rsel_q;
    rptr_d        = rptr_q;
    if (pop) begin
      if (last) begin
        rptr_d = '0;
        rsel_d = ~rsel_q;
      end else begin
        rptr_d = rptr_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsel_q <= 1'b0;
      rptr_q <= '0;
    end else begin
      rsel_q <= rsel_d;
      rptr_q <= rptr_d;
    end
  end

  assign rd_slot = rsel_q;
  assign rd_addr = rptr_q;

  AST_NO_POP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !ready) |=> ($stable(rptr_q) && $stable(rsel_q))); // R7
  AST_PTR_IN_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (CW'(rptr_q) < cnt[rsel_q])); // R8
endmodule

// File: rtl/usb_out_pingpong.sv
module usb_out_pingpong
  import usbo_pkg::*;
#(
  parameter int SLOT_BYTES = 128,
  localparam int AW        = $clog2(SLOT_BYTES),
  localparam int CW        = $clog2(SLOT_BYTES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_sop,
  input  logic          rx_valid,
  input  logic [7:0]    rx_data,
  input  logic          rx_eop,
  input  logic          rx_crc_ok,
  input  logic          tok_out,
  output logic          hs_ack,
  output logic          hs_nak,
  input  logic          cpu_rd,
  output logic [31:0]   cpu_rdata,
  output logic [CW-1:0] slot0_len,
  output logic [CW-1:0] slot1_len,
  output logic          irq,
  input  logic          irq_clr
);
  logic [1:0]         rst_sync_q;
  logic               rst_int_n;
  logic [1:0]         full_vec;
  logic [1:0][CW-1:0] len_vec;
  logic               wr_en, wr_slot, commit, commit_slot;
  logic [AW-1:0]      wr_addr, rd_addr;
  logic [CW-1:0]      commit_len;
  logic               ready, rd_slot, release_pulse;
  logic [7:0]         ram_q;
  hs_e                hs;
  logic               irq_q, irq_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  usbo_rx_fill #(.SLOT_BYTES(SLOT_BYTES)) u_fill (
    .clk(clk), .rst_n(rst_int_n), .sop(rx_sop), .valid(rx_valid), .eop(rx_eop),
    .crc_ok(rx_crc_ok), .tok(tok_out), .slot_full(full_vec), .wr_en(wr_en),
    .wr_slot(wr_slot), .wr_addr(wr_addr), .commit(commit),
    .commit_slot(commit_slot), .commit_len(commit_len), .hs(hs)
  );

  usbo_slot_ram #(.NSLOT(2), .SLOT_BYTES(SLOT_BYTES)) u_ram (
    .clk(clk), .wr_en(wr_en), .wr_slot(wr_slot), .wr_addr(wr_addr),
    .wr_data(rx_data), .rd_slot(rd_slot), .rd_addr(rd_addr), .rd_q(ram_q)
  );

  usbo_rd_drain #(.SLOT_BYTES(SLOT_BYTES)) u_drain (
    .clk(clk), .rst_n(rst_int_n), .rd(cpu_rd), .slot_full(full_vec),
    .cnt(len_vec), .ready(ready), .rd_slot(rd_slot), .rd_addr(rd_addr),
    .release_pulse(release_pulse)
  );

  for (genvar s = 0; s < 2; s++) begin : g_slot
    logic          full_q, full_d, set_s, clr_s;
    logic [CW-1:0] len_q, len_d;

    always_comb begin
      set_s  = commit && (commit_slot == 1'(s));
      clr_s  = release_pulse && (rd_slot == 1'(s));
      full_d = (full_q | set_s) & ~clr_s;
      len_d  = set_s ? commit_len : len_q;
    end

    always_ff @(posedge clk or negedge rst_int_n) begin
      if (!rst_int_n) begin
        full_q <= 1'b0;
        len_q  <= '0;
      end else begin
        full_q <= full_d;
        len_q  <= len_d;
      end
    end

    assign full_vec[s] = full_q;
    assign len_vec[s]  = len_q;

    AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_int_n)
      (full_q && !(release_pulse && rd_slot == 1'(s))) |=> full_q); // R8
  end

  always_comb begin
    irq_d = commit | (irq_q & ~irq_clr) | (irq_clr & full_vec[0] & full_vec[1]);
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) irq_q <= 1'b0;
    else            irq_q <= irq_d;
  end

  assign irq       = irq_q;
  assign hs_ack    = (hs == HS_ACK);
  assign hs_nak    = (hs == HS_NAK);
  assign cpu_rdata = {24'h000000, ready ? ram_q : 8'h00};
  assign slot0_len = len_vec[0];
  assign slot1_len = len_vec[1];

  AST_IRQ_ON_COMMIT: assert property (@(posedge clk) disable iff (!rst_int_n)
    commit |=> irq); // R3
  AST_NAK_BOTH_FULL: assert property (@(posedge clk) disable iff (!rst_int_n)
    (tok_out && (&full_vec)) |=> hs_nak); // R8
endmodule

// File: tb/tb_usb_out_pingpong.sv
module tb_usb_out_pingpong;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n, rx_sop, rx_valid, rx_eop, rx_crc_ok, tok_out;
  logic [7:0]  rx_data;
  logic        hs_ack, hs_nak, cpu_rd, irq, irq_clr;
  logic [31:0] cpu_rdata;
  logic [7:0]  slot0_len, slot1_len;
  int          n_checks = 0;
  int          n_fail = 0;
  int          cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  usb_out_pingpong dut (
    .clk(clk), .rst_n(rst_n), .rx_sop(rx_sop), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_eop(rx_eop), .rx_crc_ok(rx_crc_ok),
    .tok_out(tok_out), .hs_ack(hs_ack), .hs_nak(hs_nak), .cpu_rd(cpu_rd),
    .cpu_rdata(cpu_rdata), .slot0_len(slot0_len), .slot1_len(slot1_len),
    .irq(irq), .irq_clr(irq_clr)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  task automatic send_pkt(input int len, input logic [7:0] seed, input bit crc);
    @(negedge clk) rx_sop = 1'b1;
    @(negedge clk) rx_sop = 1'b0;
    for (int i = 0; i < len; i++) begin
      rx_valid = 1'b1;
      rx_data  = seed + 8'(i);
      @(negedge clk);
    end
    rx_valid  = 1'b0;
    rx_eop    = 1'b1;
    rx_crc_ok = crc;
    @(negedge clk) rx_eop = 1'b0;
  endtask

  task automatic token(input bit exp_ack, input string tag);
    @(negedge clk) tok_out = 1'b1;
    @(negedge clk) tok_out = 1'b0;
    chk(hs_ack == exp_ack && hs_nak == !exp_ack, tag, {hs_ack, hs_nak}, {exp_ack, !exp_ack});
  endtask

  task automatic clear_irq(input bit exp_irq, input string tag);
    @(negedge clk) irq_clr = 1'b1;
    @(negedge clk) irq_clr = 1'b0;
    chk(irq == exp_irq, tag, irq, exp_irq);
  endtask

  task automatic read_bytes(input int n, input logic [7:0] seed, input int start, input string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(cpu_rdata == {24'h0, seed + 8'(start + i)}, tag, cpu_rdata, {24'h0, seed + 8'(start + i)});
      cpu_rd = 1'b1;
    end
    @(negedge clk) cpu_rd = 1'b0;
  endtask

  task automatic read_empty(input string tag);
    @(negedge clk);
    chk(cpu_rdata == 32'h0, tag, cpu_rdata, 0);
    cpu_rd = 1'b1;
    @(negedge clk) cpu_rd = 1'b0;
    chk(cpu_rdata == 32'h0, tag, cpu_rdata, 0);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; rx_sop = 1'b0; rx_valid = 1'b0; rx_eop = 1'b0; rx_crc_ok = 1'b0;
    rx_data = 8'h00; tok_out = 1'b0; cpu_rd = 1'b0; irq_clr = 1'b0;
    repeat (3) @(negedge clk);
    chk(irq == 0 && hs_ack == 0 && hs_nak == 0, "R1 flags in reset", {irq, hs_ack, hs_nak}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(slot0_len == 0 && slot1_len == 0, "R1 lengths", {slot0_len, slot1_len}, 0);
    chk(cpu_rdata == 0 && irq == 0, "R1 data and irq", cpu_rdata, 0);
  endtask

  task automatic t_fill_two;
    read_empty("R7 empty read");
    token(1'b1, "R8 ack when empty");
    send_pkt(5, 8'h10, 1'b1);
    chk(slot0_len == 8'd5, "R2 slot0 length", slot0_len, 5);
    chk(irq == 1'b1, "R3 irq after packet", irq, 1);
    clear_irq(1'b0, "R3 clear with one slot full");
    token(1'b1, "R8 ack with one slot free");
    send_pkt(128, 8'h80, 1'b1);
    chk(slot1_len == 8'd128, "R2 slot1 length max", slot1_len, 128);
    chk(irq == 1'b1, "R3 irq after second packet", irq, 1);
    token(1'b0, "R8 nak both full");
    clear_irq(1'b1, "R3 clear with both full keeps irq");
    send_pkt(3, 8'hC0, 1'b1);
    chk(slot0_len == 8'd5 && slot1_len == 8'd128, "R10 start into full slot ignored",
        {slot0_len, slot1_len}, {8'd5, 8'd128});
  endtask

  task automatic t_drain_first;
    read_bytes(4, 8'h10, 0, "R6 bytes of first packet");
    token(1'b0, "R8 nak after partial drain");
    @(negedge clk);
    chk(cpu_rdata[31:8] == 0, "R6 upper bits zero", cpu_rdata[31:8], 0);
    read_bytes(1, 8'h10, 4, "R10 first packet intact");
    token(1'b1, "R8 ack after last byte");
  endtask

  task automatic t_discard;
    clear_irq(1'b0, "R3 clear with one slot full");
    send_pkt(7, 8'h33, 1'b0);
    chk(irq == 1'b0, "R4 bad crc no irq", irq, 0);
    chk(slot0_len == 8'd5, "R4 bad crc length kept", slot0_len, 5);
    token(1'b1, "R4 slot still free after bad crc");
    send_pkt(129, 8'h44, 1'b1);
    chk(irq == 1'b0 && slot0_len == 8'd5, "R5 overrun dropped", {irq, slot0_len}, 5);
    send_pkt(0, 8'h00, 1'b1);
    chk(irq == 1'b0 && slot0_len == 8'd5, "R5 zero length dropped", {irq, slot0_len}, 5);
    token(1'b1, "R5 slot still free after drops");
  endtask

  task automatic t_order;
    send_pkt(1, 8'hF0, 1'b1);
    chk(slot0_len == 8'd1, "R2 slot0 reused", slot0_len, 1);
    read_bytes(128, 8'h80, 0, "R9 second packet next in order");
    read_bytes(1, 8'hF0, 0, "R9 third packet after wrap");
    read_empty("R7 empty after drain");
    token(1'b1, "R8 ack when all drained");
  endtask

  initial begin
    t_reset();
    t_fill_two();
    t_drain_first();
    t_discard();
    t_order();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule